// File: doc/BRIEF.md
# Four-Channel DMA Request Controller

This block arbitrates four device request lines and, for the winning channel, runs bus transfers between memory and an I/O device. Each channel holds a 16-bit address and a 16-bit transfer count. Software loads them one byte at a time through a small register port, low byte first. A mode register per channel sets the direction, the addressing direction, reload on completion and the service mode. Single mode releases the bus after each transfer. Block mode runs to the end of the count. Demand mode runs while the request line is held.

During a transfer, the block raises address enable and pulls the granted channel's acknowledge low. It drives the current address and asserts the memory and I/O strobe pair that fits the direction. Each transfer then moves the address by one and lowers the count by one. A count loaded with N-1 gives N transfers, and the terminal-count output marks the last one. Masks, a software request, a global disable and a choice between fixed and rotating priority decide which requests may win. A status read reports the completion flags and the live request lines.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset the bus side is idle (`aen` low, all `dack_n` high, all four strobes high), every channel is masked, and the status byte reads 0 while no request is present.
- R2: A write to offset 2c loads the address of channel c and a write to offset 2c+1 loads its count. One shared pointer picks the byte: low byte first, then high byte, toggling on every write to offsets 0 to 7. A write to offset 0xC returns the pointer to the low byte.
- R3: The mode byte written at offset 0xB holds the channel in bits 1:0, the kind in bits 3:2, reload in bit 4, decrement in bit 5 and the service mode in bits 7:6. Kind 10 (memory to I/O) drives `mem_rd_n` and `io_wr_n` low. Kind 01 (I/O to memory) drives `io_rd_n` and `mem_wr_n` low. Kind 00 drives no strobe. In every case `aen` is high and only the granted channel's `dack_n` is low.
- R4: One transfer takes one clock. The address then moves by +1, or by -1 when bit 5 is set, wrapping at 16 bits. A count of N-1 yields exactly N transfers, and `tc` is high during the last one.
- R5: Service mode 01 (single) makes one transfer per grant and then returns to idle for at least one cycle.
- R6: Service mode 10 (block) keeps transferring until the count is exhausted, even if the request line drops.
- R7: Service mode 00 (demand) keeps transferring while the request is high. A transfer already in progress completes. A later request resumes at the next address.
- R8: At terminal count the channel's status flag is set and its software request is cleared. If reload (bit 4) is clear, the channel masks itself. If reload is set, the starting address and count are restored and the channel stays unmasked.
- R9: Reading offset 8 returns the terminal-count flags in bits 3:0 and the request lines (device OR software) in bits 7:4. The read clears the terminal-count flags.
- R10: With control bit 4 clear, channel 0 has the highest priority and channel 3 the lowest. With bit 4 set, the channel after the one last served is highest.
- R11: With control bit 2 (offset 8 write) set, no new transfer is granted.
- R12: Offset 0xA sets or clears one mask: channel in bits 1:0, value in bit 2. Offset 0xF writes all four masks from bits 3:0. Offset 0xE clears all masks. Offset 9 sets or clears one software request using the same channel-and-bit format as offset 0xA.
- R13: A write to offset 0xD sets all masks and clears the status flags, software requests, control bits and byte pointer. It also ends any transfer run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per byte |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_ofs | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data (status at offset 8, else 0) |
| dreq | input | 4 | Device request lines, active high |
| dack_n | output | 4 | Channel acknowledges, active low |
| aen | output | 1 | Address enable, high while the block owns the bus |
| mem_addr | output | 16 | Transfer address |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| tc | output | 1 | High during the final transfer of a count |

## Verification
The transfer engine runs on a table of channel setups: block and single runs with increasing addresses, decrementing block and demand runs, a zero count, and an address that wraps past 0xFFFF. Comparing the transfer count, the longest back-to-back run and the last address separates the three release rules and the two step directions. Directed cases then pulse a request against block mode and drop it mid-run in demand mode. Further cases hold two requests under fixed and then rotating priority, which tells a static order from one that moves after each grant. The remaining cases cover the reload, self-mask, software-request, disable, master-clear and byte-pointer paths.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int CH_N   = 4;
    localparam int CH_W   = $clog2(CH_N);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OFS_W  = 4;

    typedef enum logic [1:0] {
        XK_VERIFY = 2'b00,
        XK_TO_MEM = 2'b01,
        XK_TO_IO  = 2'b10,
        XK_RSVD   = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        SV_DEMAND  = 2'b00,
        SV_SINGLE  = 2'b01,
        SV_BLOCK   = 2'b10,
        SV_CASCADE = 2'b11
    } svc_mode_e;

    // Mirrors bits 7:2 of the mode byte.
    typedef struct packed {
        svc_mode_e  svc;
        logic       down;
        logic       reload;
        xfer_kind_e kind;
    } chan_cfg_t;

    typedef enum logic {ST_IDLE, ST_XFER} fsm_e;

    localparam logic [OFS_W-1:0] OFS_CTRL    = 4'h8;
    localparam logic [OFS_W-1:0] OFS_SWREQ   = 4'h9;
    localparam logic [OFS_W-1:0] OFS_MASK1   = 4'hA;
    localparam logic [OFS_W-1:0] OFS_MODE    = 4'hB;
    localparam logic [OFS_W-1:0] OFS_PTRCLR  = 4'hC;
    localparam logic [OFS_W-1:0] OFS_MCLR    = 4'hD;
    localparam logic [OFS_W-1:0] OFS_UNMASK  = 4'hE;
    localparam logic [OFS_W-1:0] OFS_MASKALL = 4'hF;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              sel_cnt,
    input  logic              hi_byte,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    input  logic              down,
    input  logic              reload,
    output logic [WORD_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_cnt
);
    logic [WORD_W-1:0] base_addr, base_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
        end else begin
            if (reload) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else if (step) begin
                cur_addr <= down ? cur_addr - 1'b1 : cur_addr + 1'b1;
                cur_cnt  <= cur_cnt - 1'b1;
            end
            if (wr_en) begin
                case ({sel_cnt, hi_byte})
                    2'b00: begin base_addr[BYTE_W-1:0] <= wdata; cur_addr[BYTE_W-1:0] <= wdata; end
                    2'b01: begin base_addr[WORD_W-1:BYTE_W] <= wdata; cur_addr[WORD_W-1:BYTE_W] <= wdata; end
                    2'b10: begin base_cnt[BYTE_W-1:0] <= wdata; cur_cnt[BYTE_W-1:0] <= wdata; end
                    default: begin base_cnt[WORD_W-1:BYTE_W] <= wdata; cur_cnt[WORD_W-1:BYTE_W] <= wdata; end
                endcase
            end
        end
    end
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb
    import dma4_pkg::*;
(
    input  logic [CH_N-1:0] req,
    input  logic            rotate,
    input  logic [CH_W-1:0] last,
    output logic            any,
    output logic [CH_W-1:0] pick
);
    logic [CH_W-1:0] idx;

    always_comb begin
        any  = 1'b0;
        pick = '0;
        idx  = '0;
        for (int i = 0; i < CH_N; i++) begin
            idx = rotate ? last + CH_W'(i + 1) : CH_W'(i);
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = idx;
            end
        end
    end
endmodule

// File: rtl/dma4_regs.sv
module dma4_regs
    import dma4_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [OFS_W-1:0]           ofs,
    input  logic [BYTE_W-1:0]          wdata,
    input  logic [CH_N-1:0]            dreq,
    input  logic                       done,
    input  logic [CH_W-1:0]            done_ch,
    output logic [BYTE_W-1:0]          rdata,
    output chan_cfg_t [CH_N-1:0]       cfg,
    output logic [CH_N-1:0]            mask,
    output logic [CH_N-1:0]            sreq,
    output logic                       dis,
    output logic                       rot,
    output logic                       ptr_hi,
    output logic                       mclr
);
    logic [CH_N-1:0] tc_flag;
    logic [CH_W-1:0] ch_sel;
    logic            st_read;

    assign mclr    = wr_en && (ofs == OFS_MCLR);
    assign ch_sel  = wdata[CH_W-1:0];
    assign st_read = rd_en && (ofs == OFS_CTRL);
    assign rdata   = (ofs == OFS_CTRL) ? {dreq | sreq, tc_flag} : '0;

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            mask    <= '1;
            sreq    <= '0;
            tc_flag <= '0;
            ptr_hi  <= 1'b0;
            dis     <= 1'b0;
            rot     <= 1'b0;
        end else begin
            if (st_read) tc_flag <= '0;
            if (wr_en) begin
                if (!ofs[OFS_W-1]) ptr_hi <= !ptr_hi;
                case (ofs)
                    OFS_CTRL:    begin dis <= wdata[2]; rot <= wdata[4]; end
                    OFS_SWREQ:   sreq[ch_sel] <= wdata[2];
                    OFS_MASK1:   mask[ch_sel] <= wdata[2];
                    OFS_PTRCLR:  ptr_hi <= 1'b0;
                    OFS_UNMASK:  mask <= '0;
                    OFS_MASKALL: mask <= wdata[CH_N-1:0];
                    default: ;
                endcase
            end
            if (done) begin
                tc_flag[done_ch] <= 1'b1;
                sreq[done_ch]    <= 1'b0;
                if (!cfg[done_ch].reload) mask[done_ch] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg <= '0;
        else if (wr_en && ofs == OFS_MODE) cfg[ch_sel] <= chan_cfg_t'(wdata[BYTE_W-1:2]);
    end

    // R1: every channel starts masked
    a_r1_reset_masked: assert property (@(posedge clk) $past(rst) |-> mask == '1);
    // R8: completion without reload leaves the channel masked
    a_r8_self_mask: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg[done_ch].reload) |=> mask[$past(done_ch)]);
    // R9: completion flags persist until a status read or master clear
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (!st_read && !mclr) |=> ((tc_flag & $past(tc_flag)) == $past(tc_flag)));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [OFS_W-1:0]  reg_ofs,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [CH_N-1:0]   dreq,
    output logic [CH_N-1:0]   dack_n,
    output logic              aen,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              tc
);
    fsm_e                 state;
    logic [CH_W-1:0]      cur_ch, last_ch, pick;
    logic [WORD_W-1:0]    ch_addr [CH_N];
    logic [WORD_W-1:0]    ch_cnt  [CH_N];
    chan_cfg_t [CH_N-1:0] cfg;
    chan_cfg_t            act_cfg;
    logic [CH_N-1:0]      mask, sreq, want;
    logic                 dis, rot, ptr_hi, mclr, any_req;
    logic                 xfer, last_xfer, keep;

    assign act_cfg   = cfg[cur_ch];
    assign xfer      = (state == ST_XFER);
    assign last_xfer = xfer && (ch_cnt[cur_ch] == '0);

    always_comb begin
        case (act_cfg.svc)
            SV_BLOCK:  keep = 1'b1;
            SV_DEMAND: keep = dreq[cur_ch] | sreq[cur_ch];
            default:   keep = 1'b0;
        endcase
    end

    dma4_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd), .ofs(reg_ofs),
        .wdata(reg_wdata), .dreq(dreq), .done(last_xfer), .done_ch(cur_ch),
        .rdata(reg_rdata), .cfg(cfg), .mask(mask), .sreq(sreq), .dis(dis),
        .rot(rot), .ptr_hi(ptr_hi), .mclr(mclr)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic sel, rel;
        assign sel     = xfer && (cur_ch == CH_W'(g));
        assign rel     = sel && last_xfer && cfg[g].reload;
        assign want[g] = (dreq[g] | sreq[g]) & ~mask[g] & (cfg[g].svc != SV_CASCADE);
        dma4_chan u_chan (
            .clk(clk), .rst(rst),
            .wr_en(reg_wr && !reg_ofs[OFS_W-1] && reg_ofs[CH_W:1] == CH_W'(g)),
            .sel_cnt(reg_ofs[0]), .hi_byte(ptr_hi), .wdata(reg_wdata),
            .step(sel && !rel), .down(cfg[g].down), .reload(rel),
            .cur_addr(ch_addr[g]), .cur_cnt(ch_cnt[g])
        );
    end

    dma4_arb u_arb (
        .req(want & {CH_N{!dis}}), .rotate(rot), .last(last_ch),
        .any(any_req), .pick(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_ch  <= '0;
            last_ch <= CH_W'(CH_N - 1);
        end else if (mclr) begin
            state <= ST_IDLE;
        end else if (state == ST_IDLE) begin
            if (any_req) begin
                state  <= ST_XFER;
                cur_ch <= pick;
            end
        end else if (last_xfer || !keep) begin
            state   <= ST_IDLE;
            last_ch <= cur_ch;
        end
    end

    assign aen      = xfer;
    assign dack_n   = xfer ? ~(CH_N'(1) << cur_ch) : '1;
    assign mem_addr = xfer ? ch_addr[cur_ch] : '0;
    assign mem_rd_n = !(xfer && act_cfg.kind == XK_TO_IO);
    assign io_wr_n  = !(xfer && act_cfg.kind == XK_TO_IO);
    assign io_rd_n  = !(xfer && act_cfg.kind == XK_TO_MEM);
    assign mem_wr_n = !(xfer && act_cfg.kind == XK_TO_MEM);
    assign tc       = last_xfer;

    // R3: at most one acknowledge active
    a_r3_one_ack: assert property (@(posedge clk) disable iff (rst) $onehot0(~dack_n));
    // R4: the channel address moves by one after a non-final transfer
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (xfer && !last_xfer && !(reg_wr && !reg_ofs[OFS_W-1]))
        |=> ch_addr[$past(cur_ch)] == ($past(act_cfg.down) ? $past(mem_addr) - 16'd1
                                                           : $past(mem_addr) + 16'd1));
    // R5: single mode releases after each transfer
    a_r5_single_release: assert property (@(posedge clk) disable iff (rst)
        (xfer && act_cfg.svc == SV_SINGLE) |=> !aen);
    // R11: a disabled controller stays idle
    a_r11_no_grant: assert property (@(posedge clk) disable iff (rst)
        (!xfer && dis) |=> !aen);
endmodule

// File: tb/test_dma4_ctrl.sv
`timescale 1ns/1ps
module test_dma4_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_ofs = 4'h0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic [3:0]  dreq = 4'h0;
    logic [3:0]  dack_n;
    logic        aen, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, tc;
    logic [15:0] mem_addr;

    always #2 clk = ~clk;

    dma4_ctrl i_dma4_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ofs(reg_ofs),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack_n(dack_n),
        .aen(aen), .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .tc(tc)
    );

    int checks = 0, failures = 0;
    int ntx, ntc, run, maxrun, nseq;
    logic [15:0] first_addr, last_addr;
    logic [3:0]  strb;
    logic [1:0]  seq [8];
    logic        prev_aen;
    logic [1:0]  prev_ch;
    logic [7:0]  rv;

    typedef struct packed {
        logic [1:0]  svc;
        logic        down;
        logic [15:0] addr;
        logic [15:0] cnt;
        logic [7:0]  n;
        logic [7:0]  run;
        logic [15:0] last;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'b10, 1'b0, 16'h1000, 16'd3, 8'd4, 8'd4, 16'h1003},
        '{2'b01, 1'b0, 16'h20FE, 16'd2, 8'd3, 8'd1, 16'h2100},
        '{2'b10, 1'b1, 16'h0001, 16'd1, 8'd2, 8'd2, 16'h0000},
        '{2'b00, 1'b1, 16'h8000, 16'd4, 8'd5, 8'd5, 16'h7FFC},
        '{2'b01, 1'b1, 16'h0000, 16'd0, 8'd1, 8'd1, 16'h0000},
        '{2'b10, 1'b0, 16'hFFFF, 16'd1, 8'd2, 8'd2, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ack_ch(input logic [3:0] a);
        for (int i = 0; i < 4; i++) if (!a[i]) return 2'(i);
        return 2'd0;
    endfunction

    function automatic logic [7:0] mb(input logic [1:0] svc, input logic dn, input logic ai,
                                      input logic [1:0] kind, input logic [1:0] ch);
        return {svc, dn, ai, kind, ch};
    endfunction

    task automatic wr(input logic [3:0] o, input logic [7:0] d);
        reg_ofs = o; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] o, output logic [7:0] d);
        reg_ofs = o; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic prog(input logic [1:0] ch, input logic [7:0] mode,
                        input logic [15:0] a, input logic [15:0] c);
        wr(4'hC, 8'h00);
        wr(4'hB, mode);
        wr({1'b0, ch, 1'b0}, a[7:0]);
        wr({1'b0, ch, 1'b0}, a[15:8]);
        wr({1'b0, ch, 1'b1}, c[7:0]);
        wr({1'b0, ch, 1'b1}, c[15:8]);
    endtask

    task automatic clear_mon();
        ntx = 0; ntc = 0; run = 0; maxrun = 0; nseq = 0;
        first_addr = '0; last_addr = '0; strb = 4'hF; prev_aen = 1'b0; prev_ch = 2'd0;
        for (int i = 0; i < 8; i++) seq[i] = 2'd0;
    endtask

    task automatic watch(input int n);
        for (int c = 0; c < n; c++) begin
            #1;
            if (aen) begin
                logic [1:0] ch;
                ch = ack_ch(dack_n);
                if (ntx == 0) first_addr = mem_addr;
                last_addr = mem_addr;
                ntx++;
                strb = {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n};
                if (tc) ntc++;
                if (!prev_aen || ch != prev_ch) begin
                    if (nseq < 8) seq[nseq] = ch;
                    nseq++;
                end
                run = (prev_aen && ch == prev_ch) ? run + 1 : 1;
                if (run > maxrun) maxrun = run;
                prev_ch = ch;
            end
            prev_aen = aen;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        reg_ofs = 4'h8; #1;
        chk("R1 aen", aen, 0);
        chk("R1 dack_n", dack_n, 4'hF);
        chk("R1 strobes", {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 4'hF);
        chk("R1 status", reg_rdata, 8'h00);
        @(negedge clk);
        dreq = 4'hF; clear_mon(); watch(6); dreq = 4'h0;
        chk("R1 masked after reset", ntx, 0);

        // Table: service modes and addressing on channel 1, memory-to-I/O
        for (int k = 0; k < 6; k++) begin
            prog(2'd1, mb(VECS[k].svc, VECS[k].down, 1'b0, 2'b10, 2'd1), VECS[k].addr, VECS[k].cnt);
            wr(4'hA, 8'h01);
            clear_mon(); dreq[1] = 1'b1; watch(40); dreq[1] = 1'b0;
            chk("R4 transfer count", ntx, 32'(VECS[k].n));
            chk("R4 last address", last_addr, 32'(VECS[k].last));
            chk("R4 tc once", ntc, 1);
            if (VECS[k].svc == 2'b01)      chk("R5 single run length", maxrun, 32'(VECS[k].run));
            else if (VECS[k].svc == 2'b10) chk("R6 block run length", maxrun, 32'(VECS[k].run));
            else                           chk("R7 demand run length", maxrun, 32'(VECS[k].run));
            chk("R3 to-io strobes", strb, 4'b0110);
            rd(4'h8, rv); chk("R9 status tc flag", rv, 8'h02);
            rd(4'h8, rv); chk("R9 read clears", rv, 8'h00);
        end
        clear_mon(); dreq[1] = 1'b1; watch(5); dreq[1] = 1'b0;
        chk("R8 self mask", ntx, 0);

        // R2 byte pointer
        wr(4'hB, mb(2'b10, 1'b0, 1'b0, 2'b01, 2'd0));
        wr(4'hC, 8'h00); wr(4'h0, 8'h11); wr(4'hC, 8'h00);
        wr(4'h0, 8'h34); wr(4'h0, 8'h12); wr(4'h1, 8'h00); wr(4'h1, 8'h00);
        wr(4'hA, 8'h00);
        clear_mon(); dreq[0] = 1'b1; watch(4); dreq[0] = 1'b0;
        chk("R2 address from pointer", first_addr, 16'h1234);
        chk("R2 count zero one transfer", ntx, 1);
        chk("R3 to-mem strobes", strb, 4'b1001);
        rd(4'h8, rv);

        // R3 verify kind
        prog(2'd2, mb(2'b10, 1'b0, 1'b0, 2'b00, 2'd2), 16'h0040, 16'd1);
        wr(4'hA, 8'h02);
        clear_mon(); dreq[2] = 1'b1; watch(6); dreq[2] = 1'b0;
        chk("R3 verify transfers", ntx, 2);
        chk("R3 verify no strobes", strb, 4'hF);
        chk("R3 verify ack channel", seq[0], 2'd2);
        rd(4'h8, rv);

        // R6 block ignores request drop
        prog(2'd2, mb(2'b10, 1'b0, 1'b0, 2'b10, 2'd2), 16'h0300, 16'd3);
        wr(4'hA, 8'h02);
        clear_mon(); dreq[2] = 1'b1; watch(1); dreq[2] = 1'b0; watch(10);
        chk("R6 block after pulse", ntx, 4);
        rd(4'h8, rv);

        // R7 demand stop and resume
        prog(2'd3, mb(2'b00, 1'b0, 1'b0, 2'b10, 2'd3), 16'h0900, 16'd9);
        wr(4'hA, 8'h03);
        clear_mon(); dreq[3] = 1'b1; watch(4); dreq[3] = 1'b0; watch(6);
        chk("R7 demand stops", ntx, 4);
        chk("R7 demand last addr", last_addr, 16'h0903);
        chk("R7 no tc", ntc, 0);
        clear_mon(); dreq[3] = 1'b1; watch(3); dreq[3] = 1'b0; watch(3);
        chk("R7 demand resumes", first_addr, 16'h0904);
        wr(4'hA, 8'h07);
        clear_mon(); dreq[3] = 1'b1; watch(4); dreq[3] = 1'b0;
        chk("R12 single mask set", ntx, 0);

        // R8 reload
        prog(2'd0, mb(2'b10, 1'b0, 1'b1, 2'b10, 2'd0), 16'h0500, 16'd1);
        wr(4'hA, 8'h00);
        clear_mon(); dreq[0] = 1'b1; watch(1); dreq[0] = 1'b0; watch(5);
        chk("R8 reload first run", ntx, 2);
        chk("R8 reload tc", ntc, 1);
        clear_mon(); dreq[0] = 1'b1; watch(1); dreq[0] = 1'b0; watch(5);
        chk("R8 reload address", first_addr, 16'h0500);
        chk("R8 reload stays unmasked", ntx, 2);
        rd(4'h8, rv);

        // R12 software request
        prog(2'd2, mb(2'b10, 1'b0, 1'b0, 2'b10, 2'd2), 16'h0777, 16'd0);
        wr(4'hA, 8'h02);
        clear_mon(); wr(4'h9, 8'h06);
        reg_ofs = 4'h8; #1;
        chk("R9 software request visible", reg_rdata, 8'h40);
        @(negedge clk);
        watch(5);
        chk("R12 software request transfer", ntx, 1);
        rd(4'h8, rv);
        chk("R8 software request cleared", rv, 8'h04);

        // R10 fixed then rotating priority
        prog(2'd0, mb(2'b01, 1'b0, 1'b1, 2'b10, 2'd0), 16'h0000, 16'd7);
        prog(2'd2, mb(2'b01, 1'b0, 1'b1, 2'b10, 2'd2), 16'h0200, 16'd7);
        wr(4'hE, 8'h00);
        clear_mon(); dreq = 4'b0101; watch(8); dreq = 4'h0; watch(2);
        chk("R10 fixed order", {seq[0], seq[1], seq[2], seq[3]}, 8'h00);
        chk("R12 clear-all mask", ntx, 4);
        wr(4'h8, 8'h10);
        clear_mon(); dreq = 4'b0101; watch(8); dreq = 4'h0; watch(2);
        chk("R10 rotating order", {seq[0], seq[1], seq[2], seq[3]}, 8'b10_00_10_00);

        // R11 disable
        wr(4'h8, 8'h04);
        clear_mon(); dreq = 4'b0101; watch(5);
        chk("R11 disabled", ntx, 0);
        wr(4'h8, 8'h00);
        clear_mon(); watch(4); dreq = 4'h0; watch(2);
        chk("R11 re-enabled", ntx > 0, 1);

        // R13 master clear
        wr(4'hF, 8'h00);
        wr(4'h0, 8'hAA);
        wr(4'hD, 8'h00);
        clear_mon(); dreq = 4'hF; watch(5);
        chk("R13 all masked", ntx, 0);
        reg_ofs = 4'h8; #1;
        chk("R13 status cleared", reg_rdata, 8'hF0);
        @(negedge clk);
        dreq = 4'h0;
        wr(4'hB, mb(2'b10, 1'b0, 1'b0, 2'b10, 2'd0));
        wr(4'h0, 8'h78); wr(4'h0, 8'h56); wr(4'h1, 8'h00); wr(4'h1, 8'h00);
        wr(4'hA, 8'h00);
        clear_mon(); dreq[0] = 1'b1; watch(4); dreq[0] = 1'b0;
        chk("R13 pointer cleared", first_addr, 16'h5678);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule